// File: doc/BRIEF.md
# Multi-mode DMA address generator

This block produces the source address, destination address and remaining byte count for one DMA channel. It works one transfer unit at a time. A load pulse captures a full configuration in a single cycle: base addresses, an address mode for each side, the unit width, a byte total and the optional two-dimensional parameters. After that, every advance strobe moves both addresses and the count on by one unit. The block that issues bus transactions reads the outputs and sends one strobe for each unit it completes.

Each side picks its own address mode. Fixed suits a device data port, increment and decrement walk a buffer, and stride adds a programmable signed step. In two-dimensional mode the block walks a number of rows of equal byte length. At the end of each row both addresses jump to that row's start plus a pitch for each side. This skips the padding between rows without copying it. The walk ends after the programmed number of rows.

Top module: `dma_addr_gen`

## Requirements
- R1: A load pulse captures the configuration. On the next cycle both addresses equal their bases and the two-dimensional row counter is cleared. Load takes priority over an advance in the same cycle.
- R2: The width select maps 0, 1, 2 and 3 to unit widths of 1, 2, 4 and 8 bytes.
- R3: Mode 0 (fixed) leaves that side's address unchanged on an advance.
- R4: Mode 1 (increment) adds the unit width to that side's address on an advance.
- R5: Mode 2 (decrement) subtracts the unit width from that side's address on an advance.
- R6: Mode 3 (stride) adds that side's 32-bit step, which may be negative in two's complement. All address arithmetic wraps modulo 2^32.
- R7: In one-dimensional mode, bytes remaining starts at the total and falls by the width on each advance. When an advance finds no more than one width left, the count goes to 0 and done asserts.
- R8: In two-dimensional mode, bytes remaining counts the bytes left in the current row. Row end is high while the current unit is the last of its row. The advance on that unit sets each address to its row start plus its pitch and reloads the row length.
- R9: In two-dimensional mode, done asserts and bytes remaining goes to 0 on the advance that completes the last programmed row.
- R10: While done is high, advance strobes change neither address nor bytes remaining, and done stays high until the next load.
- R11: After reset both addresses and bytes remaining are 0, done is 1 and row end is 0.
- R12: A load with a zero byte total (one-dimensional), or a zero row length or zero row count (two-dimensional), gives done on the next cycle with bytes remaining 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture configuration and restart |
| advance | input | 1 | One transfer unit completed |
| cfg_width_sel | input | 2 | Unit width select (1/2/4/8 bytes) |
| cfg_src_mode | input | 2 | Source address mode |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_src_base | input | 32 | Source start address |
| cfg_dst_base | input | 32 | Destination start address |
| cfg_src_step | input | 32 | Source stride step |
| cfg_dst_step | input | 32 | Destination stride step |
| cfg_total_bytes | input | 24 | Byte total for a one-dimensional transfer |
| cfg_2d_en | input | 1 | Enable row-by-row walk |
| cfg_row_len | input | 24 | Bytes per row |
| cfg_src_pitch | input | 32 | Source distance between row starts |
| cfg_dst_pitch | input | 32 | Destination distance between row starts |
| cfg_row_cnt | input | 16 | Number of rows |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| bytes_left | output | 24 | Bytes remaining (in the row when 2D) |
| row_end | output | 1 | Current unit is the last of its row |
| done | output | 1 | Transfer finished |

## Verification
The hardest case to reach is the final row boundary of a two-dimensional walk. There the row wrap and the terminal condition coincide, and a wrong row counter either stops one row early or runs on past the end. The bench programs a three-row walk with two units per row and different pitches on the two sides. It steps one advance at a time and checks the addresses, the count and the row-end flag after every unit. It then sends extra strobes to confirm that nothing moves. Address wrap at both ends of the 32-bit space is reached with bases placed one unit from the boundary.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic [1:0] {
    AM_FIXED  = 2'd0,
    AM_INC    = 2'd1,
    AM_DEC    = 2'd2,
    AM_STRIDE = 2'd3
  } addr_mode_e;

  function automatic logic [3:0] unit_bytes(input logic [1:0] sel);
    return 4'd1 << sel;
  endfunction
endpackage

// File: rtl/dma_ag_side.sv
module dma_ag_side #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step_en,
  input  logic          row_wrap,
  input  logic [3:0]    wbytes,
  input  logic [1:0]    mode_in,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] pitch,
  output logic [AW-1:0] addr
);
  import dma_ag_pkg::*;

  addr_mode_e    mode_q;
  logic [AW-1:0] step_q, pitch_q, row_start_q, addr_q, delta;
  logic [AW-1:0] wext;

  assign wext = {{(AW-4){1'b0}}, wbytes};

  always_comb begin
    unique case (mode_q)
      AM_FIXED:  delta = '0;
      AM_INC:    delta = wext;
      AM_DEC:    delta = '0 - wext;
      default:   delta = step_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= AM_FIXED;
      step_q      <= '0;
      pitch_q     <= '0;
      row_start_q <= '0;
      addr_q      <= '0;
    end else if (load) begin
      mode_q      <= addr_mode_e'(mode_in);
      step_q      <= step;
      pitch_q     <= pitch;
      row_start_q <= base;
      addr_q      <= base;
    end else if (step_en) begin
      if (row_wrap) begin
        row_start_q <= row_start_q + pitch_q;
        addr_q      <= row_start_q + pitch_q;
      end else begin
        addr_q      <= addr_q + delta;
      end
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma_ag_count.sv
module dma_ag_count #(
  parameter int CW = 24,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          advance,
  input  logic [3:0]    wbytes,
  input  logic [CW-1:0] total,
  input  logic          en2d,
  input  logic [CW-1:0] row_len,
  input  logic [RW-1:0] row_cnt,
  output logic          step_en,
  output logic          row_wrap,
  output logic [CW-1:0] bytes_left,
  output logic          row_end,
  output logic          done
);
  logic [CW-1:0] left_q, row_len_q, wext;
  logic [RW-1:0] rows_q, row_cnt_q;
  logic [RW:0]   rows_nx;
  logic          done_q, en2d_q, last_unit, last_row;

  assign wext      = {{(CW-4){1'b0}}, wbytes};
  assign last_unit = (left_q <= wext);
  assign rows_nx   = {1'b0, rows_q} + 1'b1;
  assign last_row  = (rows_nx == {1'b0, row_cnt_q});
  assign step_en   = advance && !done_q && !load;
  assign row_wrap  = en2d_q && last_unit;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q    <= '0;
      row_len_q <= '0;
      rows_q    <= '0;
      row_cnt_q <= '0;
      en2d_q    <= 1'b0;
      done_q    <= 1'b1;
    end else if (load) begin
      en2d_q    <= en2d;
      row_len_q <= row_len;
      row_cnt_q <= row_cnt;
      rows_q    <= '0;
      if (en2d) begin
        done_q <= (row_len == '0) || (row_cnt == '0);
        left_q <= (row_cnt == '0) ? '0 : row_len;
      end else begin
        done_q <= (total == '0);
        left_q <= total;
      end
    end else if (step_en) begin
      if (!last_unit) begin
        left_q <= left_q - wext;
      end else if (en2d_q && !last_row) begin
        left_q <= row_len_q;
        rows_q <= rows_nx[RW-1:0];
      end else begin
        left_q <= '0;
        done_q <= 1'b1;
      end
    end
  end

  assign bytes_left = left_q;
  assign row_end    = en2d_q && last_unit && !done_q;
  assign done       = done_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          advance,
  input  logic [1:0]    cfg_width_sel,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic [AW-1:0] cfg_src_base,
  input  logic [AW-1:0] cfg_dst_base,
  input  logic [AW-1:0] cfg_src_step,
  input  logic [AW-1:0] cfg_dst_step,
  input  logic [CW-1:0] cfg_total_bytes,
  input  logic          cfg_2d_en,
  input  logic [CW-1:0] cfg_row_len,
  input  logic [AW-1:0] cfg_src_pitch,
  input  logic [AW-1:0] cfg_dst_pitch,
  input  logic [RW-1:0] cfg_row_cnt,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic [CW-1:0] bytes_left,
  output logic          row_end,
  output logic          done
);
  import dma_ag_pkg::*;

  localparam int NSIDE = 2;

  logic [3:0]    wbytes_q;
  logic          step_en, row_wrap;
  logic [1:0]    mode_a  [NSIDE];
  logic [AW-1:0] base_a  [NSIDE];
  logic [AW-1:0] step_a  [NSIDE];
  logic [AW-1:0] pitch_a [NSIDE];
  logic [AW-1:0] addr_a  [NSIDE];

  assign mode_a[0]  = cfg_src_mode;
  assign mode_a[1]  = cfg_dst_mode;
  assign base_a[0]  = cfg_src_base;
  assign base_a[1]  = cfg_dst_base;
  assign step_a[0]  = cfg_src_step;
  assign step_a[1]  = cfg_dst_step;
  assign pitch_a[0] = cfg_src_pitch;
  assign pitch_a[1] = cfg_dst_pitch;

  always_ff @(posedge clk) begin
    if (rst)       wbytes_q <= 4'd1;
    else if (load) wbytes_q <= unit_bytes(cfg_width_sel);
  end

  dma_ag_count #(.CW(CW), .RW(RW)) u_count (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .wbytes(wbytes_q), .total(cfg_total_bytes), .en2d(cfg_2d_en),
    .row_len(cfg_row_len), .row_cnt(cfg_row_cnt),
    .step_en(step_en), .row_wrap(row_wrap), .bytes_left(bytes_left),
    .row_end(row_end), .done(done)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_ag_side #(.AW(AW)) u_side (
      .clk(clk), .rst(rst), .load(load), .step_en(step_en),
      .row_wrap(row_wrap), .wbytes(wbytes_q), .mode_in(mode_a[g]),
      .base(base_a[g]), .step(step_a[g]), .pitch(pitch_a[g]),
      .addr(addr_a[g])
    );
  end

  assign src_addr = addr_a[0];
  assign dst_addr = addr_a[1];
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          advance,
  input logic          cfg_2d_en,
  input logic [1:0]    cfg_width_sel,
  input logic [AW-1:0] cfg_src_base,
  input logic [AW-1:0] cfg_dst_base,
  input logic [AW-1:0] src_addr,
  input logic [AW-1:0] dst_addr,
  input logic [CW-1:0] bytes_left,
  input logic          row_end,
  input logic          done
);
  logic          sh_2d;
  logic [CW-1:0] sh_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_2d <= 1'b0;
      sh_w  <= CW'(1);
    end else if (load) begin
      sh_2d <= cfg_2d_en;
      sh_w  <= CW'(dma_ag_pkg::unit_bytes(cfg_width_sel));
    end
  end

  assert_load_base_R1: assert property (@(posedge clk) disable iff (rst)
    load |=> (src_addr == $past(cfg_src_base)) && (dst_addr == $past(cfg_dst_base)));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && !load && !done && !sh_2d && bytes_left > sh_w)
      |=> bytes_left == $past(bytes_left) - sh_w);

  assert_row_end_live_R8: assert property (@(posedge clk) disable iff (rst)
    row_end |-> (!done && bytes_left != '0));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> done);

  assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (rst)
    (done && !load) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(bytes_left)));

  assert_reset_state_R11: assert property (@(posedge clk)
    rst |=> (done && bytes_left == '0 && !row_end));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .load(load), .advance(advance),
  .cfg_2d_en(cfg_2d_en), .cfg_width_sel(cfg_width_sel),
  .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
  .src_addr(src_addr), .dst_addr(dst_addr), .bytes_left(bytes_left),
  .row_end(row_end), .done(done)
);

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0, advance = 1'b0;
  logic [1:0]  cfg_width_sel = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
  logic [31:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic [31:0] cfg_src_step = '0, cfg_dst_step = '0;
  logic [23:0] cfg_total_bytes = '0, cfg_row_len = '0;
  logic        cfg_2d_en = 1'b0;
  logic [31:0] cfg_src_pitch = '0, cfg_dst_pitch = '0;
  logic [15:0] cfg_row_cnt = '0;
  logic [31:0] src_addr, dst_addr;
  logic [23:0] bytes_left;
  logic        row_end, done;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  dma_addr_gen u_dut (
    .clk(clk), .rst(rst), .load(load), .advance(advance),
    .cfg_width_sel(cfg_width_sel), .cfg_src_mode(cfg_src_mode),
    .cfg_dst_mode(cfg_dst_mode), .cfg_src_base(cfg_src_base),
    .cfg_dst_base(cfg_dst_base), .cfg_src_step(cfg_src_step),
    .cfg_dst_step(cfg_dst_step), .cfg_total_bytes(cfg_total_bytes),
    .cfg_2d_en(cfg_2d_en), .cfg_row_len(cfg_row_len),
    .cfg_src_pitch(cfg_src_pitch), .cfg_dst_pitch(cfg_dst_pitch),
    .cfg_row_cnt(cfg_row_cnt), .src_addr(src_addr), .dst_addr(dst_addr),
    .bytes_left(bytes_left), .row_end(row_end), .done(done)
  );

  typedef struct packed {
    logic [1:0]  sm, dm, ws;
    logic [31:0] sb, db, ss, ds;
    logic [23:0] tot;
    logic [3:0]  nadv;
    logic [31:0] es, ed;
    logic [23:0] el;
    logic        edone;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    // R3 fixed source, R4 incrementing destination
    '{2'd0, 2'd1, 2'd2, 32'h1000_0000, 32'h8000_0000, 32'h0, 32'h0, 24'd64, 4'd3,
      32'h1000_0000, 32'h8000_000C, 24'd52, 1'b0, 4'd4},
    // R5 decrement source, R6 stride destination
    '{2'd2, 2'd3, 2'd1, 32'h200, 32'h4000, 32'h0, 32'h100, 24'd10, 4'd4,
      32'h1F8, 32'h4400, 24'd2, 1'b0, 4'd5},
    // R7 final unit reaches zero
    '{2'd2, 2'd3, 2'd1, 32'h200, 32'h4000, 32'h0, 32'h100, 24'd10, 4'd5,
      32'h1F6, 32'h4500, 24'd0, 1'b1, 4'd7},
    // R10 extra strobes after done
    '{2'd2, 2'd3, 2'd1, 32'h200, 32'h4000, 32'h0, 32'h100, 24'd10, 4'd7,
      32'h1F6, 32'h4500, 24'd0, 1'b1, 4'd10},
    // R6 wrap at both ends of the address space, 8-byte units (R2)
    '{2'd2, 2'd1, 2'd3, 32'h4, 32'hFFFF_FFF8, 32'h0, 32'h0, 24'd100, 4'd1,
      32'hFFFF_FFFC, 32'h0, 24'd92, 1'b0, 4'd6},
    // R2 byte units
    '{2'd1, 2'd1, 2'd0, 32'h10, 32'h20, 32'h0, 32'h0, 24'd3, 4'd2,
      32'h12, 32'h22, 24'd1, 1'b0, 4'd2},
    // R12 zero total
    '{2'd1, 2'd1, 2'd2, 32'h30, 32'h40, 32'h0, 32'h0, 24'd0, 4'd0,
      32'h30, 32'h40, 24'd0, 1'b1, 4'd12},
    // R7 total not a multiple of width
    '{2'd1, 2'd1, 2'd2, 32'h0, 32'h100, 32'h0, 32'h0, 24'd6, 4'd2,
      32'h8, 32'h108, 24'd0, 1'b1, 4'd7},
    // R6 negative stride, R3 fixed destination
    '{2'd3, 2'd0, 2'd2, 32'h100, 32'h50, 32'hFFFF_FFF0, 32'h0, 24'd40, 4'd3,
      32'hD0, 32'h50, 24'd28, 1'b0, 4'd6}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_load();
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic do_adv(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); advance = 1'b1;
    end
    @(negedge clk); advance = 1'b0;
  endtask

  task automatic chk_state(input string req, input logic [31:0] es, input logic [31:0] ed,
                           input logic [23:0] el, input logic ere, input logic edn);
    chk(req, "src_addr", src_addr, es);
    chk(req, "dst_addr", dst_addr, ed);
    chk(req, "bytes_left", {8'h0, bytes_left}, {8'h0, el});
    chk(req, "row_end", {31'h0, row_end}, {31'h0, ere});
    chk(req, "done", {31'h0, done}, {31'h0, edn});
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk_state("R11", 32'h0, 32'h0, 24'd0, 1'b0, 1'b1);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      cfg_src_mode = VEC[v].sm; cfg_dst_mode = VEC[v].dm;
      cfg_width_sel = VEC[v].ws;
      cfg_src_base = VEC[v].sb; cfg_dst_base = VEC[v].db;
      cfg_src_step = VEC[v].ss; cfg_dst_step = VEC[v].ds;
      cfg_total_bytes = VEC[v].tot; cfg_2d_en = 1'b0;
      do_load();
      if (VEC[v].nadv != 0) do_adv(int'(VEC[v].nadv));
      chk($sformatf("R%0d", VEC[v].req), "vec src", src_addr, VEC[v].es);
      chk($sformatf("R%0d", VEC[v].req), "vec dst", dst_addr, VEC[v].ed);
      chk($sformatf("R%0d", VEC[v].req), "vec left", {8'h0, bytes_left}, {8'h0, VEC[v].el});
      chk($sformatf("R%0d", VEC[v].req), "vec done", {31'h0, done}, {31'h0, VEC[v].edone});
    end

    // R1 load wins over a simultaneous advance, and restarts a finished transfer
    cfg_src_mode = 2'd1; cfg_dst_mode = 2'd1; cfg_width_sel = 2'd2;
    cfg_src_base = 32'hA000; cfg_dst_base = 32'hB000; cfg_total_bytes = 24'd16;
    @(negedge clk); load = 1'b1; advance = 1'b1;
    @(negedge clk); load = 1'b0; advance = 1'b0;
    chk_state("R1", 32'hA000, 32'hB000, 24'd16, 1'b0, 1'b0);

    // R8 R9 two-dimensional walk: 4-byte units, 8-byte rows, 3 rows
    cfg_2d_en = 1'b1; cfg_row_len = 24'd8; cfg_row_cnt = 16'd3;
    cfg_src_base = 32'h1000; cfg_dst_base = 32'h2000;
    cfg_src_pitch = 32'd32; cfg_dst_pitch = 32'd16;
    do_load();
    chk_state("R8", 32'h1000, 32'h2000, 24'd8, 1'b0, 1'b0);
    do_adv(1); chk_state("R8", 32'h1004, 32'h2004, 24'd4, 1'b1, 1'b0);
    do_adv(1); chk_state("R8", 32'h1020, 32'h2010, 24'd8, 1'b0, 1'b0);
    do_adv(1); chk_state("R8", 32'h1024, 32'h2014, 24'd4, 1'b1, 1'b0);
    do_adv(1); chk_state("R8", 32'h1040, 32'h2020, 24'd8, 1'b0, 1'b0);
    do_adv(1); chk_state("R9", 32'h1044, 32'h2024, 24'd4, 1'b1, 1'b0);
    do_adv(1); chk_state("R9", 32'h1060, 32'h2030, 24'd0, 1'b0, 1'b1);
    do_adv(3); chk_state("R10", 32'h1060, 32'h2030, 24'd0, 1'b0, 1'b1);

    // R12 zero row count in two-dimensional mode
    cfg_row_cnt = 16'd0;
    do_load();
    chk_state("R12", 32'h1000, 32'h2000, 24'd0, 1'b0, 1'b1);

    // R1 reload clears the row counter: a second full walk also needs 3 rows
    cfg_row_cnt = 16'd3;
    do_load();
    do_adv(5); chk_state("R1", 32'h1044, 32'h2024, 24'd4, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule